// File: doc/BRIEF.md
# Infrared Line Run-Length Sampler

This block watches one infrared receiver line and turns it into a stream of run-length symbols. The line is sampled once per tick of a programmable prescaler, optionally inverted, and passed through a glitch filter that holds the current level until a new level has persisted for a programmed number of samples. The filtered level is then measured in sample periods. Each finished run leaves the block as an 8-bit symbol that carries the level and the run length.

A packet opens only after the line has shown a mark (a pulse) for an activity threshold, and those opening samples are not reported. It closes when the line has rested in space for an idle threshold. At that point the pending space run is pushed out as a last symbol and a one-clock packet-end pulse follows. A downstream FIFO and decoder consume the symbol strobe and the packet-end pulse. The configuration inputs are static words whose field positions are given below.

Top module: `ir_run_sampler`

## Requirements
- R1: One sample is taken every 2^DIV_LO_LOG2 clocks when `smp_cfg[0]` is 0 and every 2^DIV_HI_LOG2 clocks when it is 1 (defaults 64 and 128), counting from the clock where the block becomes enabled.
- R2: When `rx_invert` is 1 the sampled line level is inverted, so a low input counts as mark and a high input counts as space.
- R3: With F in `smp_cfg[7:2]`, the filtered level changes only after F+1 consecutive samples that differ from it. Shorter excursions are absorbed into the current run.
- R4: With A in `smp_cfg[22:16]` and the scale bit `smp_cfg[23]`, a packet opens once the filtered mark has lasted (A+1) samples, or (A+1)·2^ACT_SCALE_LOG2 samples when the scale bit is 1. These opening samples are not reported, and a shorter mark produces no output at all.
- R5: Symbol bit 7 is 1 for mark and 0 for space, and bits 6:0 hold the run length minus one in samples. A symbol is pushed on the sample where the filtered level changes.
- R6: A run that reaches 128 samples is pushed as level with length field 127, and counting carries on in a new symbol of the same level.
- R7: With N in `smp_cfg[15:8]`, the packet closes on the sample where the space run reaches (N+1)·2^IDLE_UNIT_LOG2 samples. The pending space run, which leaves out that closing sample, is pushed as the final symbol.
- R8: `pkt_end` is high for exactly one clock, on the clock after the final symbol's strobe. After that the block waits for a new activity threshold.
- R9: The block runs only while `ctl_word[0]` and `ctl_word[1]` are both 1 and `ctl_word[5:4]` equals 2'b11. Otherwise all its state is held cleared and neither output strobe rises.
- R10: After reset both strobes are low. `sym_valid` is high for single clocks, one clock after the sample edge that produced the symbol, and `sym_data` is meaningful only while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_word | input | 6 | Bit 0 global enable, bit 1 receive enable, bits 5:4 mode (2'b11 = run-length mode) |
| rx_invert | input | 1 | Invert line polarity |
| smp_cfg | input | 24 | Bit 0 rate select, 7:2 glitch threshold, 15:8 idle threshold, 22:16 activity threshold minus one, 23 activity scale |
| ir_in | input | 1 | Receiver line, synchronous to clk |
| sym_valid | output | 1 | Symbol push strobe |
| sym_data | output | 8 | Level in bit 7, run length minus one in bits 6:0 |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
The assertions check on every cycle that the strobes stay silent while the block is disabled, that symbol strobes never sit on consecutive clocks, and that each packet-end pulse lasts one clock and comes right after a pushed space symbol. The exact run lengths cannot be seen by a property that only looks at the ports: how many samples the activity threshold swallows, how glitches fold into runs, where a long run is split and the size of the flushed remainder. The bench shows these by comparing against a behavioural model on every clock and by checking exact symbol sequences for held line patterns.

// File: rtl/irs_pkg.sv
package irs_pkg;

    // Symbol layout: level in the top bit, run length minus one below it.
    localparam int SYM_W  = 8;
    localparam int RUN_W  = SYM_W - 1;
    // Configuration field widths (positions fixed by the configuration word).
    localparam int FILT_W = 6;
    localparam int IDLE_W = 8;
    localparam int ACT_W  = 7;

    typedef enum logic {
        ENC_WAIT = 1'b0,
        ENC_RUN  = 1'b1
    } enc_state_e;

endpackage

// File: rtl/irs_tick_gen.sv
module irs_tick_gen #(
    parameter int LO_LOG2 = 6,
    parameter int HI_LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_hi,
    output logic tick
);

    localparam int CNT_W = (HI_LOG2 > LO_LOG2) ? HI_LOG2 : LO_LOG2;
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'((32'd1 << LO_LOG2) - 32'd1);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'((32'd1 << HI_LOG2) - 32'd1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        div_d = div_q;
        limit = sel_hi ? LIM_HI : LIM_LO;
        tick  = en && (div_q.cnt == limit);
        if (!en) begin
            div_d.cnt = '0;
        end else if (tick) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/irs_glitch_filter.sv
module irs_glitch_filter
    import irs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              din,
    input  logic [FILT_W-1:0] thr,
    output logic              lvl_o
);

    typedef struct packed {
        logic              lvl;
        logic [FILT_W-1:0] gcnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (!en) begin
            flt_d = '0;
        end else if (tick) begin
            if (din == flt_q.lvl) begin
                flt_d.gcnt = '0;
            end else if (flt_q.gcnt >= thr) begin
                flt_d.lvl  = din;
                flt_d.gcnt = '0;
            end else begin
                flt_d.gcnt = flt_q.gcnt + FILT_W'(1);
            end
        end
        lvl_o = flt_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

endmodule

// File: rtl/irs_run_encoder.sv
module irs_run_encoder
    import irs_pkg::*;
#(
    parameter int IDLE_UNIT_LOG2 = 7,
    parameter int ACT_SCALE_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              lvl,
    input  logic [IDLE_W-1:0] idle_n,
    input  logic [ACT_W-1:0]  act_m1,
    input  logic              act_scale,
    output logic              sym_valid,
    output logic [SYM_W-1:0]  sym_data,
    output logic              pkt_end
);

    localparam int ACT_LEN_W  = ACT_W + 1 + ACT_SCALE_LOG2;
    localparam int IDLE_LEN_W = IDLE_W + 1 + IDLE_UNIT_LOG2;
    localparam int RUN_CW     = RUN_W + 1;
    localparam logic [RUN_CW-1:0] RUN_MAX = RUN_CW'(32'd1 << RUN_W);

    typedef struct packed {
        enc_state_e            state;
        logic [ACT_LEN_W-1:0]  act_cnt;
        logic                  run_lvl;
        logic [RUN_CW-1:0]     run_cnt;
        logic [IDLE_LEN_W-1:0] idle_cnt;
        logic                  sym_v;
        logic [SYM_W-1:0]      sym;
        logic                  end_pend;
        logic                  pkt_end;
    } enc_t;

    enc_t enc_d, enc_q;

    logic [ACT_LEN_W-1:0]  act_base;
    logic [ACT_LEN_W-1:0]  act_len;
    logic [IDLE_LEN_W-1:0] idle_len;
    logic [RUN_W-1:0]      run_field;
    logic                  idle_hit;

    always_comb begin
        act_base  = ACT_LEN_W'(act_m1) + ACT_LEN_W'(1);
        act_len   = act_scale ? (act_base << ACT_SCALE_LOG2) : act_base;
        idle_len  = (IDLE_LEN_W'(idle_n) + IDLE_LEN_W'(1)) << IDLE_UNIT_LOG2;
        run_field = RUN_W'(enc_q.run_cnt - RUN_CW'(1));
        idle_hit  = !lvl && ((enc_q.idle_cnt + IDLE_LEN_W'(1)) == idle_len);

        enc_d          = enc_q;
        enc_d.sym_v    = 1'b0;
        enc_d.end_pend = 1'b0;
        enc_d.pkt_end  = enc_q.end_pend;

        if (!en) begin
            enc_d = '0;
        end else if (tick) begin
            unique case (enc_q.state)
                ENC_WAIT: begin
                    if (lvl) begin
                        if ((enc_q.act_cnt + ACT_LEN_W'(1)) >= act_len) begin
                            enc_d.state    = ENC_RUN;
                            enc_d.act_cnt  = '0;
                            enc_d.run_lvl  = 1'b1;
                            enc_d.run_cnt  = '0;
                            enc_d.idle_cnt = '0;
                        end else begin
                            enc_d.act_cnt = enc_q.act_cnt + ACT_LEN_W'(1);
                        end
                    end else begin
                        enc_d.act_cnt = '0;
                    end
                end
                ENC_RUN: begin
                    if (idle_hit) begin
                        if (enc_q.run_cnt != '0) begin
                            enc_d.sym_v = 1'b1;
                            enc_d.sym   = {enc_q.run_lvl, run_field};
                        end
                        enc_d.end_pend = 1'b1;
                        enc_d.state    = ENC_WAIT;
                        enc_d.act_cnt  = '0;
                        enc_d.run_lvl  = 1'b0;
                        enc_d.run_cnt  = '0;
                        enc_d.idle_cnt = '0;
                    end else begin
                        enc_d.idle_cnt = lvl ? '0 : (enc_q.idle_cnt + IDLE_LEN_W'(1));
                        if (lvl == enc_q.run_lvl) begin
                            if (enc_q.run_cnt == RUN_MAX) begin
                                enc_d.sym_v   = 1'b1;
                                enc_d.sym     = {enc_q.run_lvl, run_field};
                                enc_d.run_cnt = RUN_CW'(1);
                            end else begin
                                enc_d.run_cnt = enc_q.run_cnt + RUN_CW'(1);
                            end
                        end else begin
                            if (enc_q.run_cnt != '0) begin
                                enc_d.sym_v = 1'b1;
                                enc_d.sym   = {enc_q.run_lvl, run_field};
                            end
                            enc_d.run_lvl = lvl;
                            enc_d.run_cnt = RUN_CW'(1);
                        end
                    end
                end
                default: enc_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_q <= '0;
        else        enc_q <= enc_d;
    end

    assign sym_valid = enc_q.sym_v;
    assign sym_data  = enc_q.sym;
    assign pkt_end   = enc_q.pkt_end;

endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
    import irs_pkg::*;
#(
    parameter int DIV_LO_LOG2    = 6,
    parameter int DIV_HI_LOG2    = 7,
    parameter int IDLE_UNIT_LOG2 = 7,
    parameter int ACT_SCALE_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       ctl_word,
    input  logic             rx_invert,
    input  logic [23:0]      smp_cfg,
    input  logic             ir_in,
    output logic             sym_valid,
    output logic [SYM_W-1:0] sym_data,
    output logic             pkt_end
);

    localparam logic [1:0] MODE_RUNLEN = 2'b11;

    logic run_en;
    logic tick;
    logic line_lvl;
    logic flt_lvl;

    assign run_en   = ctl_word[0] && ctl_word[1] && (ctl_word[5:4] == MODE_RUNLEN);
    assign line_lvl = ir_in ^ rx_invert;

    irs_tick_gen #(
        .LO_LOG2 (DIV_LO_LOG2),
        .HI_LOG2 (DIV_HI_LOG2)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run_en),
        .sel_hi (smp_cfg[0]),
        .tick   (tick)
    );

    irs_glitch_filter u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .tick  (tick),
        .din   (line_lvl),
        .thr   (smp_cfg[7:2]),
        .lvl_o (flt_lvl)
    );

    irs_run_encoder #(
        .IDLE_UNIT_LOG2 (IDLE_UNIT_LOG2),
        .ACT_SCALE_LOG2 (ACT_SCALE_LOG2)
    ) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .tick      (tick),
        .lvl       (flt_lvl),
        .idle_n    (smp_cfg[15:8]),
        .act_m1    (smp_cfg[22:16]),
        .act_scale (smp_cfg[23]),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .pkt_end   (pkt_end)
    );

endmodule

// File: rtl/ir_run_sampler_chk.sv
module ir_run_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ctl_word,
    input logic       sym_valid,
    input logic [7:0] sym_data,
    input logic       pkt_end
);

    logic chk_en;
    assign chk_en = ctl_word[0] && ctl_word[1] && (ctl_word[5:4] == 2'b11);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> (!sym_valid && !pkt_end)); // R9

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end); // R8

    AST_END_AFTER_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> ($past(sym_valid) && !$past(sym_data[7]))); // R7

    AST_SYM_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid); // R10

    AST_NO_SYM_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> !sym_valid); // R8

endmodule

bind ir_run_sampler ir_run_sampler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_word  (ctl_word),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .pkt_end   (pkt_end)
);

// File: tb/ir_run_sampler_test.sv
`timescale 1ns/1ps
module ir_run_sampler_test;

    localparam int LO = 1;
    localparam int HI = 2;
    localparam int IU = 2;
    localparam int AS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ctl_word = '0;
    logic       rx_invert = 1'b0;
    logic [23:0] smp_cfg = '0;
    logic       ir_in = 1'b0;
    logic       sym_valid;
    logic [7:0] sym_data;
    logic       pkt_end;

    ir_run_sampler #(
        .DIV_LO_LOG2 (LO), .DIV_HI_LOG2 (HI),
        .IDLE_UNIT_LOG2 (IU), .ACT_SCALE_LOG2 (AS)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ctl_word (ctl_word), .rx_invert (rx_invert),
        .smp_cfg (smp_cfg), .ir_in (ir_in),
        .sym_valid (sym_valid), .sym_data (sym_data), .pkt_end (pkt_end)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R10";
    int div_clks = 2;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int  m_div, m_gc, m_act, m_rcnt, m_idle;
    bit  m_flt, m_run, m_rlvl, m_pend, m_sv, m_pe;
    int  m_sd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_gc = 0; m_act = 0; m_rcnt = 0; m_idle = 0;
            m_flt = 0; m_run = 0; m_rlvl = 0; m_pend = 0; m_sv = 0; m_pe = 0; m_sd = 0;
        end else begin
            bit on;
            on = ctl_word[0] && ctl_word[1] && ctl_word[5:4] == 2'b11;
            m_pe = m_pend; m_pend = 0; m_sv = 0;
            if (!on) begin
                m_div = 0; m_gc = 0; m_act = 0; m_rcnt = 0; m_idle = 0;
                m_flt = 0; m_run = 0; m_rlvl = 0; m_pe = 0; m_sd = 0;
            end else begin
                int lim;
                lim = smp_cfg[0] ? (1 << HI) - 1 : (1 << LO) - 1;
                if (m_div != lim) begin
                    m_div = (m_div + 1) % (1 << HI);
                end else begin
                    bit s;
                    int alen, ilen;
                    m_div = 0;
                    s = ir_in ^ rx_invert;
                    if (s == m_flt) m_gc = 0;
                    else if (m_gc >= int'(smp_cfg[7:2])) begin m_flt = s; m_gc = 0; end
                    else m_gc++;
                    alen = (int'(smp_cfg[22:16]) + 1) * (smp_cfg[23] ? (1 << AS) : 1);
                    ilen = (int'(smp_cfg[15:8]) + 1) * (1 << IU);
                    if (!m_run) begin
                        if (m_flt) begin
                            m_act++;
                            if (m_act >= alen) begin
                                m_run = 1; m_act = 0; m_rlvl = 1; m_rcnt = 0; m_idle = 0;
                            end
                        end else m_act = 0;
                    end else if (!m_flt && m_idle + 1 == ilen) begin
                        if (m_rcnt > 0) begin m_sv = 1; m_sd = m_rlvl * 128 + m_rcnt - 1; end
                        m_pend = 1; m_run = 0; m_rcnt = 0; m_idle = 0; m_rlvl = 0;
                    end else begin
                        m_idle = m_flt ? 0 : m_idle + 1;
                        if (m_flt == m_rlvl) begin
                            if (m_rcnt == 128) begin
                                m_sv = 1; m_sd = m_rlvl * 128 + 127; m_rcnt = 1;
                            end else m_rcnt++;
                        end else begin
                            if (m_rcnt > 0) begin m_sv = 1; m_sd = m_rlvl * 128 + m_rcnt - 1; end
                            m_rlvl = m_flt; m_rcnt = 1;
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison and capture, away from the rising edge.
    int cyc = 0;
    int syms[$];
    int n_pe = 0;
    int last_sym_cyc = -10;
    int pe_gap_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(sym_valid == m_sv, {cur_req, " strobe"}, sym_valid, m_sv);
            chk(pkt_end == m_pe, {cur_req, " R8 pkt_end"}, pkt_end, m_pe);
            if (sym_valid && m_sv)
                chk(int'(sym_data) == m_sd, {cur_req, " data"}, sym_data, m_sd);
            if (sym_valid) begin syms.push_back(int'(sym_data)); last_sym_cyc = cyc; end
            if (pkt_end) begin
                n_pe++;
                if (cyc - last_sym_cyc != 1) pe_gap_bad++;
            end
        end
    end

    task automatic hold(input bit lvl, input int n);
        ir_in = lvl ^ rx_invert;
        repeat (n * div_clks) @(negedge clk);
    endtask

    task automatic scen(input string req, input bit sel, input int filt, input int idle,
                        input int act, input bit scale, input bit inv);
        ctl_word = '0;
        repeat (3) @(negedge clk);
        cur_req = req;
        syms.delete();
        n_pe = 0;
        smp_cfg = {scale, 7'(act), 8'(idle), 6'(filt), 1'b0, sel};
        rx_invert = inv;
        ir_in = inv;
        div_clks = sel ? (1 << HI) : (1 << LO);
        ctl_word = 6'b110011;
    endtask

    task automatic expect_syms(input string req, input int exp[$]);
        chk(syms.size() == exp.size(), {req, " count"}, syms.size(), exp.size());
        for (int i = 0; i < exp.size() && i < syms.size(); i++)
            chk(syms[i] == exp[i], req, syms[i], exp[i]);
    endtask

    bit done = 0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sym_valid == 0, "R10 reset strobe", sym_valid, 0);
        chk(pkt_end == 0, "R10 reset pkt_end", pkt_end, 0);
        rst_n = 1'b1;

        // R9: wrong mode, then receive enable off
        scen("R9", 0, 0, 0, 0, 0, 0);
        ctl_word = 6'b000011;
        hold(1, 10); hold(0, 12); hold(1, 5);
        ctl_word = 6'b110001;
        hold(0, 3); hold(1, 10); hold(0, 12);
        chk(syms.size() == 0, "R9 no symbols", syms.size(), 0);
        chk(n_pe == 0, "R9 no pkt_end", n_pe, 0);

        // R5 / R7 / R8: basic packet
        scen("R5", 0, 0, 0, 0, 0, 0);
        hold(1, 10); hold(0, 2); hold(1, 3); hold(0, 12);
        expect_syms("R5 seq", '{8'h88, 8'h01, 8'h82, 8'h02});
        chk(n_pe == 1, "R8 one pkt_end", n_pe, 1);
        chk(pe_gap_bad == 0, "R8 pkt_end follows last symbol", pe_gap_bad, 0);

        // R2: inverted line
        scen("R2", 0, 0, 0, 0, 0, 1);
        hold(1, 5); hold(0, 12);
        expect_syms("R2 seq", '{8'h83, 8'h02});

        // R3: glitch filter of 3 samples
        scen("R3", 0, 2, 0, 0, 0, 0);
        hold(1, 10); hold(0, 2); hold(1, 5); hold(0, 14);
        expect_syms("R3 seq", '{8'h8F, 8'h02});

        // R4: activity threshold, unscaled then scaled
        scen("R4", 0, 0, 0, 9, 0, 0);
        hold(1, 6); hold(0, 12);
        chk(syms.size() == 0 && n_pe == 0, "R4 short mark ignored", syms.size(), 0);
        hold(1, 15); hold(0, 12);
        expect_syms("R4 seq", '{8'h84, 8'h02});
        scen("R4", 0, 0, 0, 0, 1, 0);
        hold(1, 6); hold(0, 12);
        chk(syms.size() == 0 && n_pe == 0, "R4 scaled short mark ignored", syms.size(), 0);
        hold(1, 20); hold(0, 12);
        expect_syms("R4 scaled seq", '{8'h8B, 8'h02});

        // R6: long mark split, then long space split before idle (R7)
        scen("R6", 0, 0, 0, 0, 0, 0);
        hold(1, 300); hold(0, 12);
        expect_syms("R6 mark split", '{8'hFF, 8'hFF, 8'hAA, 8'h02});
        scen("R7", 0, 0, 80, 0, 0, 0);
        hold(1, 3); hold(0, 330);
        expect_syms("R7 space split", '{8'h81, 8'h7F, 8'h7F, 8'h42});
        chk(n_pe == 1, "R7 one pkt_end", n_pe, 1);

        // R1: slow sample rate
        scen("R1", 1, 0, 0, 0, 0, 0);
        hold(1, 10); hold(0, 12);
        expect_syms("R1 seq", '{8'h88, 8'h02});

        chk(pe_gap_bad == 0, "R8 pkt_end spacing overall", pe_gap_bad, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule